// File: doc/BRIEF.md
# Collatz Trajectory Test Unit

This unit takes one starting value and follows its Collatz trajectory, one map step per clock, in a 128-bit working register. An even value is halved. An odd value becomes three times itself plus one. A run ends in one of three ways. It succeeds as soon as a step produces a value below the starting value. It raises an alert with cause "overflow" when the odd step result does not fit in 128 bits. It raises an alert with cause "timeout" when 8192 steps have run without success.

An outside scheduler watches `ready_o` and hands over a new starting value with `load_i`. A supervisor watches `alert_o`. While the alert is raised, the supervisor reads the cause and the starting value that caused it. It then releases the unit with `clear_i`. After a clear the unit is in the same idle state it enters after a success.

Top module: `collatz_unit`

## Requirements
- R1: Each clock in a run performs exactly one map step. An even value is halved. An odd value n becomes 3n+1. The step that produces the terminating value counts as a step.
- R2: When a step produces a value strictly below the starting value, `done_o` is high for exactly one cycle after that step's clock edge. `ready_o` rises at the same edge and `cause_o` stays 2'b00.
- R3: When an odd step's 3n+1 result does not fit in 128 bits, the run stops. `alert_o` rises after that step's edge with `cause_o` = 2'b01.
- R4: When the 8192nd step still does not produce a value below the start, `alert_o` rises after that step's edge with `cause_o` = 2'b10.
- R5: While alerted the unit does no steps and `ready_o` stays low. A `load_i` strobe during the alert changes neither the cause nor the readback value.
- R6: While `alert_o` is high, `culprit_o` shows the starting value of the run that raised it and holds it. Otherwise `culprit_o` is zero.
- R7: `clear_i` while alerted returns the unit to idle at the next edge: `ready_o`=1, `alert_o`=0, `cause_o`=2'b00. `clear_i` at any other time has no effect on a run or on idle.
- R8: `load_i` is accepted only while `ready_o` is high. A strobe during a run does not change that run's starting value or its outcome.
- R9: After reset the unit is idle: `ready_o`=1, `done_o`=0, `alert_o`=0, `cause_o`=2'b00, `culprit_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_o | output | 1 | Idle and able to take a starting value |
| load_i | input | 1 | Strobe that takes `seed_i` when ready |
| seed_i | input | 128 | Starting value |
| done_o | output | 1 | One-cycle success pulse |
| alert_o | output | 1 | Run stopped on overflow or timeout |
| cause_o | output | 2 | 00 none, 01 overflow, 10 timeout |
| culprit_o | output | 128 | Starting value of the alerted run, zero otherwise |
| clear_i | input | 1 | Releases an alert |

## Verification
The assertions assume a reset at the start, and they assume that `load_i` and `clear_i` are single-bit strobes sampled only at the rising edge. The assertions make no assumption about when the strobes arrive. This covers the cases where they come at illegal times, such as a load mid-run or a clear while idle. The stimulus drives every strobe half a cycle away from the active edge and holds it for one full cycle. It also deliberately issues loads and clears while running and while alerted, so that the "ignored" paths are exercised.

// File: rtl/collatz_pkg.sv
package collatz_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } unit_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_OVF  = 2'b01,
        CAUSE_TMO  = 2'b10
    } alert_cause_e;

endpackage

// File: rtl/collatz_step.sv
module collatz_step #(
    parameter int W = 128
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o,
    output logic         ovf_o
);
    localparam int EW = W + 2;

    logic [EW-1:0] wide_cur;
    logic [EW-1:0] tripled;

    always_comb begin
        wide_cur = {2'b00, cur_i};
        tripled  = (wide_cur << 1) + wide_cur + EW'(1);
        if (cur_i[0]) begin
            nxt_o = tripled[W-1:0];
            ovf_o = |tripled[EW-1:W];
        end else begin
            nxt_o = {1'b0, cur_i[W-1:1]};
            ovf_o = 1'b0;
        end
    end

    // an even step can never overflow
    always_comb begin
        if (!cur_i[0]) begin
            p_even_no_ovf_r3 : assert (!ovf_o);
        end
    end
endmodule

// File: rtl/collatz_below.sv
module collatz_below #(
    parameter int W = 128
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] ref_i,
    output logic         lt_o
);
    assign lt_o = (val_i < ref_i);
endmodule

// File: rtl/collatz_unit.sv
module collatz_unit
    import collatz_pkg::*;
#(
    parameter int W     = 128,
    parameter int LIMIT = 8192
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    output logic         ready_o,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    output logic         done_o,
    output logic         alert_o,
    output logic [1:0]   cause_o,
    output logic [W-1:0] culprit_o,
    input  logic         clear_i
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(LIMIT - 1);

    typedef struct packed {
        unit_state_e  st;
        logic [W-1:0] cur;
        logic [W-1:0] seed;
        logic [CW-1:0] steps;
        logic         done;
        alert_cause_e cause;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [W-1:0] nxt_w;
    logic         ovf_w;
    logic         below_w;

    collatz_step #(.W(W)) u_step (
        .cur_i (regs_q.cur),
        .nxt_o (nxt_w),
        .ovf_o (ovf_w)
    );

    collatz_below #(.W(W)) u_below (
        .val_i (nxt_w),
        .ref_i (regs_q.seed),
        .lt_o  (below_w)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (load_i) begin
                    regs_d.st    = ST_RUN;
                    regs_d.cur   = seed_i;
                    regs_d.seed  = seed_i;
                    regs_d.steps = '0;
                end
            end
            ST_RUN: begin
                if (ovf_w) begin
                    regs_d.st    = ST_HALT;
                    regs_d.cause = CAUSE_OVF;
                end else if (below_w) begin
                    regs_d.st   = ST_IDLE;
                    regs_d.done = 1'b1;
                end else if (regs_q.steps == LAST_STEP) begin
                    regs_d.st    = ST_HALT;
                    regs_d.cause = CAUSE_TMO;
                end else begin
                    regs_d.cur   = nxt_w;
                    regs_d.steps = regs_q.steps + CW'(1);
                end
            end
            ST_HALT: begin
                if (clear_i) begin
                    regs_d.st    = ST_IDLE;
                    regs_d.cause = CAUSE_NONE;
                end
            end
            default: begin
                regs_d.st    = ST_IDLE;
                regs_d.cause = CAUSE_NONE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.st    <= ST_IDLE;
            regs_q.cur   <= '0;
            regs_q.seed  <= '0;
            regs_q.steps <= '0;
            regs_q.done  <= 1'b0;
            regs_q.cause <= CAUSE_NONE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ready_o   = (regs_q.st == ST_IDLE);
    assign alert_o   = (regs_q.st == ST_HALT);
    assign done_o    = regs_q.done;
    assign cause_o   = regs_q.cause;
    assign culprit_o = alert_o ? regs_q.seed : '0;

    // R2: success is a single-cycle pulse
    p_done_pulse_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R2: success leaves the unit ready and without a cause
    p_done_ready_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (ready_o && cause_o == 2'b00));
    // R3: an overflow alert follows a step that flagged overflow
    p_ovf_source_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(alert_o) && cause_o == 2'b01) |-> $past(ovf_w));
    // R4: the step counter never passes the limit
    p_steps_bound_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        regs_q.steps <= LAST_STEP);
    // R5: never ready and alerted together
    p_ready_excl_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ready_o && alert_o));
    // R5: an alert holds its cause until cleared
    p_cause_hold_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alert_o && !clear_i) |=> (alert_o && $stable(cause_o)));
    // R6: readback is stable while alerted
    p_culprit_hold_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alert_o && !clear_i) |=> $stable(culprit_o));
    // R7: a clear during an alert returns to idle
    p_clear_idle_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alert_o && clear_i) |=> (ready_o && !alert_o && cause_o == 2'b00));
    // R8: the starting value of a run cannot change while busy
    p_seed_hold_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ready_o && $past(!ready_o)) |-> $stable(regs_q.seed));
endmodule

// File: tb/collatz_unit_tb.sv
module collatz_unit_tb;
    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ready, load = 1'b0, done, alert, clear = 1'b0;
    logic [W-1:0] seed = '0;
    logic [1:0]   cause;
    logic [W-1:0] culprit;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    collatz_unit u_dut (
        .clk_i(clk), .rst_ni(rst_n), .ready_o(ready), .load_i(load),
        .seed_i(seed), .done_o(done), .alert_o(alert), .cause_o(cause),
        .culprit_o(culprit), .clear_i(clear)
    );

    // {expected cause, starting value}
    localparam logic [129:0] VEC [9] = '{
        {2'b00, 128'd3},
        {2'b00, 128'd7},
        {2'b00, 128'd27},
        {2'b00, 128'd2},
        {2'b00, 128'd1000001},
        {2'b01, {1'b1, 126'd0, 1'b1}},
        {2'b01, {1'b0, {127{1'b1}}}},
        {2'b00, {2'b01, 125'd0, 1'b1}},
        {2'b00, {1'b1, 127'd0}}
    };

    task automatic chk(input string req, input logic [129:0] act, input logic [129:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [127:0] s, output int steps, output logic [1:0] c);
        logic [129:0] n, t;
        n = {2'b00, s};
        steps = 0;
        c = 2'b11;
        for (int i = 1; i <= 8192; i++) begin
            t = n[0] ? (n * 3 + 130'd1) : (n >> 1);
            if (t[129:128] != 2'b00) begin steps = i; c = 2'b01; return; end
            if (t < {2'b00, s})       begin steps = i; c = 2'b00; return; end
            if (i == 8192)            begin steps = i; c = 2'b10; return; end
            n = t;
        end
    endfunction

    // load a value, optionally poke load or clear at one step, count steps to the end
    task automatic launch(input logic [127:0] v, input int poke_at, input logic poke_load,
                          input logic poke_clear, output int steps);
        @(negedge clk);
        seed = v;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        steps = 0;
        while (!done && !alert && steps < 9000) begin
            if (steps == poke_at) begin
                load  = poke_load;
                clear = poke_clear;
                seed  = {1'b1, 126'd0, 1'b1};
            end
            @(negedge clk);
            load  = 1'b0;
            clear = 1'b0;
            steps++;
        end
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    initial begin
        wait (cyc >= 150000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int st, ms;
        logic [1:0] mc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 ready", 130'(ready), 130'd1);
        chk("R9 done", 130'(done), 130'd0);
        chk("R9 alert", 130'(alert), 130'd0);
        chk("R9 cause", 130'(cause), 130'd0);
        chk("R9 culprit", 130'(culprit), 130'd0);

        foreach (VEC[i]) begin
            model(VEC[i][127:0], ms, mc);
            launch(VEC[i][127:0], -1, 1'b0, 1'b0, st);
            chk("R1 step count", 130'(st), 130'(ms));
            chk("R2/R3 cause", 130'(cause), 130'(VEC[i][129:128]));
            if (VEC[i][129:128] == 2'b00) begin
                chk("R2 done", 130'(done), 130'd1);
                chk("R2 ready", 130'(ready), 130'd1);
                chk("R6 culprit zero", 130'(culprit), 130'd0);
                @(negedge clk);
                chk("R2 pulse ends", 130'(done), 130'd0);
            end else begin
                chk("R3 alert", 130'(alert), 130'd1);
                chk("R6 culprit", 130'(culprit), 130'(VEC[i][127:0]));
                chk("R5 not ready", 130'(ready), 130'd0);
                do_clear();
                chk("R7 ready", 130'(ready), 130'd1);
                chk("R7 alert", 130'(alert), 130'd0);
                chk("R7 cause", 130'(cause), 130'd0);
                chk("R6 culprit cleared", 130'(culprit), 130'd0);
            end
        end

        // R8: a load mid-run with an overflowing seed has no effect
        model(128'd27, ms, mc);
        launch(128'd27, 5, 1'b1, 1'b0, st);
        chk("R8 steps", 130'(st), 130'(ms));
        chk("R8 cause", 130'(cause), 130'd0);
        chk("R8 done", 130'(done), 130'd1);

        // R4 timeout, with an ignored clear mid-run (R7)
        launch(128'd1, 100, 1'b0, 1'b1, st);
        chk("R4 steps", 130'(st), 130'd8192);
        chk("R4 cause", 130'(cause), 130'd2);
        chk("R4 alert", 130'(alert), 130'd1);
        chk("R6 culprit", 130'(culprit), 130'd1);

        // R5: alert holds and ignores loads
        repeat (5) @(negedge clk);
        chk("R5 still alert", 130'(alert), 130'd1);
        seed = 128'd3;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
        chk("R5 alert after load", 130'(alert), 130'd1);
        chk("R5 cause after load", 130'(cause), 130'd2);
        chk("R5 culprit after load", 130'(culprit), 130'd1);
        chk("R5 ready low", 130'(ready), 130'd0);
        do_clear();
        chk("R7 ready after timeout", 130'(ready), 130'd1);

        // R7: clear while idle has no effect
        do_clear();
        chk("R7 idle clear ready", 130'(ready), 130'd1);
        chk("R7 idle clear alert", 130'(alert), 130'd0);
        launch(128'd3, -1, 1'b0, 1'b0, st);
        chk("R7 run after idle clear", 130'(st), 130'd6);
        chk("R2 done after idle clear", 130'(done), 130'd1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule